// File: doc/BRIEF.md
# Modulated Fractional Baud-Rate Generator

This block derives the bit timing of an asynchronous serial link from a source clock whose frequency is not an integer multiple of the baud rate. A base divide ratio N sets the length of each bit period. An 8-entry stretch pattern, indexed by the position of the bit within the frame, lengthens selected periods by one source cycle. The average bit period can then land between N and N+1. This keeps the accumulated error small across a frame, even when the source is a 32768 Hz clock. The stretch pattern comes either straight from an 8-bit pattern input or from a 3-bit count that picks one of eight evenly spread patterns.

In oversampling mode each bit period is split into 16 sub-periods. A first modulator, driven by a 4-bit fine setting, spreads single-cycle stretches evenly over those 16 sub-periods. A pulse marks the end of each sub-period. The position pattern then acts as a second modulator: its stretch cycle is added to the last sub-period of the bit. The receive line is sampled at the ends of sub-periods 7, 8 and 9, and the majority of the three samples becomes the recovered bit.

A frame-start pulse, given when the start-bit edge is seen, restarts all timing at bit position 0. The generator then runs freely and wraps the position after 7.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset and before the first frame-start pulse, neither `bit_tick_o` nor `os_tick_o` is asserted, and `rx_bit_o` reads 1.
- R2: A divide value below 3 on `prescale_i` (0, 1 or 2) behaves exactly as a divide value of 3.
- R3: With `os_mode_i`=0, the period for frame position p lasts N + m[p] source cycles, where m is the stretch pattern. `bit_tick_o` is high for exactly one cycle: the last cycle of each period. The first period begins in the cycle after the one in which `frame_start_i` is high.
- R4: With `use_count_i`=0, bit p of `mod_byte_i` is m[p] (position 0, the start bit, uses bit 0). For example, N=3 with pattern 0x4A gives periods 3,4,3,4,3,3,4,3.
- R5: With `use_count_i`=1, a count S on `mod_count_i` selects the stretched positions: S=0 none; 1 → {1}; 2 → {1,5}; 3 → {1,3,5}; 4 → {1,3,5,7}; 5 → {1,2,3,5,7}; 6 → {1,2,3,5,6,7}; 7 → {1..7}. Position 0 is never stretched.
- R6: The position index is 0 for the first period after a frame start. It counts up by one per bit and wraps from 7 to 0, so positions 8 and 9 reuse m[0] and m[1].
- R7: With `os_mode_i`=1, each bit period is 16 sub-periods k=0..15. Sub-period k lasts N + s(k) cycles, plus m[p] when k=15, where s(k) = floor((k+1)·F/16) − floor(k·F/16) and F=`fine_mod_i`. `os_tick_o` pulses in the last cycle of every sub-period. With `os_mode_i`=0, `os_tick_o` stays low.
- R8: In oversampling mode, `bit_tick_o` pulses only together with the os tick that ends sub-period 15.
- R9: In oversampling mode, `rx_i` is sampled in the cycles in which the os ticks ending sub-periods 7, 8 and 9 are high. `rx_bit_o` takes the majority of the three samples one cycle after the sub-period-9 tick and holds it until the next such update.
- R10: A frame-start pulse in the middle of a period drops the current period and restarts the timing at position 0, sub-period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 15 | Base divide ratio N |
| use_count_i | input | 1 | 1: pattern from count setting, 0: pattern from byte |
| mod_byte_i | input | 8 | Direct stretch pattern, bit p for position p |
| mod_count_i | input | 3 | Number of stretched positions in count mode |
| os_mode_i | input | 1 | 1: 16x oversampling mode |
| fine_mod_i | input | 4 | Stretches spread over the 16 sub-periods |
| frame_start_i | input | 1 | Pulse that restarts timing at position 0 |
| rx_i | input | 1 | Receive line for the majority vote |
| bit_tick_o | output | 1 | One-cycle pulse ending each bit period |
| os_tick_o | output | 1 | One-cycle pulse ending each sub-period |
| rx_bit_o | output | 1 | Majority-voted receive bit |

## Verification
Some checks run on every cycle. The assertions check that the bit tick never lasts two cycles, that no sub-period tick appears outside oversampling mode, that a bit tick in that mode always coincides with a sub-period tick, and that a counter loaded at frame start is never shorter than the clamped minimum. They also check that a frame start puts the position and sub-period at 0, that the count-mode pattern has exactly S ones with position 0 clear, and that the voted bit changes only just after the sub-period-9 sample. Other behaviour shows only in the bench scenarios. These cover the exact length of each period for every count setting and several divide values, including the wrap past position 7, the 0x4A and 0x34 cases, the clamping of small divide values, and every fine setting. They also cover the restart in the middle of a bit and the vote result for all eight sample combinations.

// File: rtl/baud_mod_pkg.sv
package baud_mod_pkg;

    localparam int POS_N = 8;
    localparam int POS_W = 3;

    // Evenly spread stretch set selected by a stretch count
    function automatic logic [POS_N-1:0] count_to_pattern(input logic [POS_W-1:0] s);
        logic [POS_N-1:0] p;
        case (s)
            3'd0:    p = 8'b0000_0000;
            3'd1:    p = 8'b0000_0010;
            3'd2:    p = 8'b0010_0010;
            3'd3:    p = 8'b0010_1010;
            3'd4:    p = 8'b1010_1010;
            3'd5:    p = 8'b1010_1110;
            3'd6:    p = 8'b1110_1110;
            default: p = 8'b1111_1110;
        endcase
        return p;
    endfunction

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/baud_mod_pattern.sv
module baud_mod_pattern
    import baud_mod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_count_i,
    input  logic [POS_N-1:0] mod_byte_i,
    input  logic [POS_W-1:0] mod_count_i,
    output logic [POS_N-1:0] pattern_o
);

    logic [POS_N-1:0] from_count;

    always_comb begin
        from_count = count_to_pattern(mod_count_i);
        pattern_o  = use_count_i ? from_count : mod_byte_i;
    end

    // R5
    count_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_count_i |-> (($countones(pattern_o) == int'(mod_count_i)) && !pattern_o[0]));

endmodule

// File: rtl/baud_seg_timer.sv
module baud_seg_timer
    import baud_mod_pkg::*;
#(
    parameter int PRESC_W  = 15,
    parameter int MIN_DIV  = 3,
    parameter int OS_RATE  = 16,
    localparam int OS_W    = $clog2(OS_RATE),
    localparam int CNT_W   = PRESC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] prescale_i,
    input  logic [POS_N-1:0]   pattern_i,
    input  logic               os_mode_i,
    input  logic [OS_W-1:0]    fine_i,
    input  logic               frame_start_i,
    output logic               bit_tick_o,
    output logic               os_tick_o,
    output logic [OS_W-1:0]    sub_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] pos;
        logic [OS_W-1:0]  sub;
    } tmr_t;

    tmr_t st_q, st_d;

    logic [PRESC_W-1:0] n_eff;
    logic               seg_end;
    logic               last_slot;

    // One stretch per sub-period whenever the running sum of fine crosses a boundary
    function automatic logic slot_stretch(input logic [OS_W-1:0] k, input logic [OS_W-1:0] f);
        logic [2*OS_W-1:0] prod;
        logic [OS_W:0]     acc;
        prod = (2*OS_W)'(k) * (2*OS_W)'(f);
        acc  = {1'b0, prod[OS_W-1:0]} + {1'b0, f};
        return acc[OS_W];
    endfunction

    function automatic logic [CNT_W-1:0] seg_len(
        input logic [OS_W-1:0]    k,
        input logic [POS_W-1:0]   p,
        input logic               os,
        input logic [PRESC_W-1:0] nb,
        input logic [POS_N-1:0]   pat,
        input logic [OS_W-1:0]    f
    );
        logic [CNT_W-1:0] len;
        len = {1'b0, nb};
        if (os && slot_stretch(k, f))
            len = len + CNT_W'(1);
        if ((!os || (k == OS_W'(OS_RATE - 1))) && pat[p])
            len = len + CNT_W'(1);
        return len;
    endfunction

    always_comb begin
        n_eff     = (prescale_i < PRESC_W'(MIN_DIV)) ? PRESC_W'(MIN_DIV) : prescale_i;
        seg_end   = st_q.run && (st_q.cnt == '0);
        last_slot = (st_q.sub == OS_W'(OS_RATE - 1));
        st_d      = st_q;

        if (frame_start_i) begin
            st_d.run = 1'b1;
            st_d.pos = '0;
            st_d.sub = '0;
            st_d.cnt = seg_len('0, '0, os_mode_i, n_eff, pattern_i, fine_i) - CNT_W'(1);
        end else if (seg_end) begin
            if (!os_mode_i || last_slot) begin
                st_d.sub = '0;
                st_d.pos = POS_W'(st_q.pos + POS_W'(1));
            end else begin
                st_d.sub = OS_W'(st_q.sub + OS_W'(1));
            end
            st_d.cnt = seg_len(st_d.sub, st_d.pos, os_mode_i, n_eff, pattern_i, fine_i) - CNT_W'(1);
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        bit_tick_o = seg_end && (!os_mode_i || last_slot);
        os_tick_o  = seg_end && os_mode_i;
        sub_o      = st_q.sub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o);

    // R7
    os_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !os_mode_i |-> !os_tick_o);

    // R8
    bit_on_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (os_mode_i && bit_tick_o) |-> os_tick_o);

    // R2
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (st_q.cnt >= CNT_W'(MIN_DIV - 1)));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> ((st_q.pos == '0) && (st_q.sub == '0) && st_q.run));

endmodule

// File: rtl/baud_maj_vote.sv
module baud_maj_vote
    import baud_mod_pkg::*;
#(
    parameter int OS_RATE  = 16,
    parameter int VOTE_MID = 8,
    localparam int OS_W    = $clog2(OS_RATE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick_i,
    input  logic [OS_W-1:0] sub_i,
    input  logic            rx_i,
    output logic            rx_bit_o
);

    typedef struct packed {
        logic early;
        logic mid;
        logic bitv;
    } vote_t;

    vote_t vt_q, vt_d;

    always_comb begin
        vt_d = vt_q;
        if (os_tick_i) begin
            if (sub_i == OS_W'(VOTE_MID - 1)) vt_d.early = rx_i;
            if (sub_i == OS_W'(VOTE_MID))     vt_d.mid   = rx_i;
            if (sub_i == OS_W'(VOTE_MID + 1)) vt_d.bitv  = majority3(vt_q.early, vt_q.mid, rx_i);
        end
        rx_bit_o = vt_q.bitv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vt_q <= '{early: 1'b1, mid: 1'b1, bitv: 1'b1};
        else        vt_q <= vt_d;
    end

    // R9
    vote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit_o) |-> $past(os_tick_i && (sub_i == OS_W'(VOTE_MID + 1))));

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_mod_pkg::*;
#(
    parameter int PRESC_W  = 15,
    parameter int MIN_DIV  = 3,
    parameter int OS_RATE  = 16,
    parameter int VOTE_MID = 8,
    localparam int OS_W    = $clog2(OS_RATE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] prescale_i,
    input  logic               use_count_i,
    input  logic [POS_N-1:0]   mod_byte_i,
    input  logic [POS_W-1:0]   mod_count_i,
    input  logic               os_mode_i,
    input  logic [OS_W-1:0]    fine_mod_i,
    input  logic               frame_start_i,
    input  logic               rx_i,
    output logic               bit_tick_o,
    output logic               os_tick_o,
    output logic               rx_bit_o
);

    logic [POS_N-1:0] pattern;
    logic [OS_W-1:0]  sub_idx;
    logic             os_tick;

    baud_mod_pattern u_pattern (
        .clk         (clk),
        .rst_n       (rst_n),
        .use_count_i (use_count_i),
        .mod_byte_i  (mod_byte_i),
        .mod_count_i (mod_count_i),
        .pattern_o   (pattern)
    );

    baud_seg_timer #(
        .PRESC_W (PRESC_W),
        .MIN_DIV (MIN_DIV),
        .OS_RATE (OS_RATE)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .prescale_i    (prescale_i),
        .pattern_i     (pattern),
        .os_mode_i     (os_mode_i),
        .fine_i        (fine_mod_i),
        .frame_start_i (frame_start_i),
        .bit_tick_o    (bit_tick_o),
        .os_tick_o     (os_tick),
        .sub_o         (sub_idx)
    );

    baud_maj_vote #(
        .OS_RATE  (OS_RATE),
        .VOTE_MID (VOTE_MID)
    ) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick_i (os_tick),
        .sub_i     (sub_idx),
        .rx_i      (rx_i),
        .rx_bit_o  (rx_bit_o)
    );

    assign os_tick_o = os_tick;

endmodule

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] presc;
    logic        use_cnt;
    logic [7:0]  mbyte;
    logic [2:0]  mcnt;
    logic        osm;
    logic [3:0]  fine;
    logic        fs;
    logic        rx;
    logic        bit_tick, os_tick, rx_bit;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    baud_frac_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .prescale_i    (presc),
        .use_count_i   (use_cnt),
        .mod_byte_i    (mbyte),
        .mod_count_i   (mcnt),
        .os_mode_i     (osm),
        .fine_mod_i    (fine),
        .frame_start_i (fs),
        .rx_i          (rx),
        .bit_tick_o    (bit_tick),
        .os_tick_o     (os_tick),
        .rx_bit_o      (rx_bit)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stretched positions per count setting, written from the requirement sets
    function automatic logic [7:0] exp_pat(input logic uc, input logic [7:0] b, input logic [2:0] s);
        logic [7:0] p;
        if (!uc) return b;
        p = '0;
        case (s)
            3'd1: p[1] = 1'b1;
            3'd2: begin p[1] = 1'b1; p[5] = 1'b1; end
            3'd3: begin p[1] = 1'b1; p[3] = 1'b1; p[5] = 1'b1; end
            3'd4: begin p[1] = 1'b1; p[3] = 1'b1; p[5] = 1'b1; p[7] = 1'b1; end
            3'd5: begin p[1] = 1'b1; p[2] = 1'b1; p[3] = 1'b1; p[5] = 1'b1; p[7] = 1'b1; end
            3'd6: begin p[1] = 1'b1; p[2] = 1'b1; p[3] = 1'b1; p[5] = 1'b1; p[6] = 1'b1; p[7] = 1'b1; end
            3'd7: for (int i = 1; i < 8; i++) p[i] = 1'b1;
            default: p = '0;
        endcase
        return p;
    endfunction

    function automatic int neff(input int n);
        return (n < 3) ? 3 : n;
    endfunction

    function automatic int sstr(input int k, input int f);
        return ((k + 1) * f) / 16 - (k * f) / 16;
    endfunction

    task automatic run_std(input int n, input logic uc, input logic [7:0] b, input logic [2:0] s,
                           input int nbits, input string tag);
        logic [7:0] pat;
        int c;
        logic got, oshit;
        pat = exp_pat(uc, b, s);
        @(negedge clk);
        presc = n[14:0]; use_cnt = uc; mbyte = b; mcnt = s; osm = 1'b0; fine = 4'd0;
        fs = 1'b1;
        oshit = 1'b0;
        for (int p = 0; p < nbits; p++) begin
            c = 0; got = 1'b0;
            while (!got && c < 70000) begin
                @(negedge clk);
                fs = 1'b0;
                c++;
                if (os_tick) oshit = 1'b1;
                if (bit_tick) got = 1'b1;
            end
            chk(c == neff(n) + int'(pat[p % 8]), tag, c, neff(n) + int'(pat[p % 8]));
        end
        chk(!oshit, "R7 os tick absent in standard mode", int'(oshit), 0);
    endtask

    task automatic run_os(input int n, input logic [3:0] f, input logic uc, input logic [2:0] s,
                          input int nbits, input logic [15:0] vec, input logic chkvote,
                          input string tag);
        logic [7:0] pat;
        int c, e;
        logic got, bt;
        pat = exp_pat(uc, 8'h00, s);
        @(negedge clk);
        presc = n[14:0]; use_cnt = uc; mbyte = 8'h00; mcnt = s; osm = 1'b1; fine = f;
        fs = 1'b1;
        for (int p = 0; p < nbits; p++) begin
            for (int k = 0; k < 16; k++) begin
                c = 0; got = 1'b0; bt = 1'b0;
                while (!got && c < 70000) begin
                    @(negedge clk);
                    fs = 1'b0;
                    rx = vec[k];
                    c++;
                    if (os_tick) begin got = 1'b1; bt = bit_tick; end
                    else if (bit_tick) bt = 1'b1;
                end
                e = neff(n) + sstr(k, int'(f)) + ((k == 15) ? int'(pat[p % 8]) : 0);
                chk(c == e, tag, c, e);
                chk(bt == (k == 15), "R8 bit tick only with sub-period 15 tick", int'(bt), int'(k == 15));
                if (k == 15 && chkvote)
                    chk(rx_bit == ((vec[7] & vec[8]) | (vec[7] & vec[9]) | (vec[8] & vec[9])),
                        "R9 majority vote", int'(rx_bit),
                        int'((vec[7] & vec[8]) | (vec[7] & vec[9]) | (vec[8] & vec[9])));
            end
        end
        rx = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic seen;
        logic [15:0] v;
        logic mj;
        rst_n = 1'b0; presc = 15'd4; use_cnt = 1'b1; mbyte = 8'h00; mcnt = 3'd0;
        osm = 1'b0; fine = 4'd0; fs = 1'b0; rx = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet and idle vote before first frame start
        seen = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (bit_tick || os_tick) seen = 1'b1;
        end
        chk(!seen, "R1 no ticks before frame start", int'(seen), 0);
        chk(rx_bit == 1'b1, "R1 vote output resets to 1", int'(rx_bit), 1);

        // R4: direct pattern byte, wrap into positions 8 and 9 (R6)
        run_std(3, 1'b0, 8'h4A, 3'd0, 10, "R4 direct pattern 0x4A period");
        run_std(52, 1'b0, 8'h00, 3'd0, 9, "R4 unmodulated divide 0x34 period");
        run_std(6, 1'b0, 8'h81, 3'd0, 10, "R4 start bit stretch from byte bit 0");

        // R5 / R6 / R3: every count setting over several divides, across the wrap
        for (int n = 3; n <= 5; n++)
            for (int s = 0; s < 8; s++)
                run_std(n, 1'b1, 8'h00, 3'(s), 10, "R5 count mode period (R3 R6)");

        // R2: small divide values clamp to 3
        for (int n = 0; n < 3; n++)
            run_std(n, 1'b1, 8'h00, 3'd7, 3, "R2 divide below 3 acts as 3");

        // R10: restart in the middle of bit 1
        @(negedge clk);
        presc = 15'd4; use_cnt = 1'b1; mcnt = 3'd1; osm = 1'b0; fs = 1'b1;
        @(negedge clk);
        fs = 1'b0;
        repeat (6) @(negedge clk);
        run_std(4, 1'b1, 8'h00, 3'd1, 3, "R10 restart mid-bit begins at position 0");

        // R7 / R8: every fine setting in oversampling mode
        for (int f = 0; f < 16; f++)
            run_os(3, 4'(f), 1'b1, 3'd3, 2, 16'hFFFF, 1'b0, "R7 sub-period length");

        // R9: all sample combinations, other slots driven against the majority
        for (int cmb = 0; cmb < 8; cmb++) begin
            mj = (cmb[0] & cmb[1]) | (cmb[0] & cmb[2]) | (cmb[1] & cmb[2]);
            v = mj ? 16'h0000 : 16'hFFFF;
            v[7] = cmb[0]; v[8] = cmb[1]; v[9] = cmb[2];
            run_os(4, 4'd5, 1'b1, 3'd0, 1, v, 1'b1, "R9 sub-period length in vote run");
        end

        finish_run();
    end

endmodule